// File: doc/BRIEF.md
# Final Score Scale-and-Accumulate Unit

This block sits at the end of a distance-scoring pipeline. Each input is a finished distance sum tagged with the index of the interleaved vector it belongs to, along with a scale coefficient and a weight. The block computes `sum * scale + weight` in a two-stage fixed-point multiply-add pipeline.

In direct mode every result leaves the block on its own. In accumulate mode the block adds results into one private accumulator per interleaved vector. It emits a single final score once that vector has collected a fixed number of mixture components. The reader then fetches one value where it would otherwise fetch eight.

Inputs arrive sporadically. The multiply-add registers are enabled only while an accepted input is in flight. A registered activity flag shows when the datapath is awake. A one-cycle clear pulse empties every accumulator before a new set of components starts.

Top module: `final_score_unit`

## Requirements
- R1: In direct mode (`acc_mode` = 0), an accepted input produces a one-cycle `out_valid` pulse three clock edges after the edge that samples it. At that pulse, `out_score` equals `in_sum * in_scale + in_weight` as a signed value, and `out_vec` equals `in_vec`.
- R2: In accumulate mode (`acc_mode` = 1), each vector index adds its products into its own accumulator. On the COMPS-th such input (8 by default), the block emits one pulse carrying the total of those COMPS products, with the same three-edge latency. The accumulator then starts empty again. Earlier inputs for that vector produce no output.
- R3: The NUM_VEC accumulators (10 by default) are independent. Inputs for different vectors may interleave in any order, back to back on consecutive cycles, without disturbing each other's totals.
- R4: A one-cycle `clr_acc` pulse empties every accumulator and resets its component count to zero. Partial sums collected before the pulse never appear in a later score.
- R5: An input with `in_vec` >= NUM_VEC is ignored. It produces no output, changes no accumulator and does not wake the datapath.
- R6: The flag `dp_active` is registered. After a given clock edge it is 1 exactly when an accepted input was sampled at that edge or at one of the two edges before it. It therefore falls one cycle after the last result leaves the multiply-add pipeline.
- R7: While `out_valid` is 0, `out_score` and `out_vec` keep the values of the last pulse.
- R8: While reset is held and right after it, `out_valid` = 0, `dp_active` = 0, `out_score` = 0 and `out_vec` = 0, and every accumulator is empty.
- R9: The mode is sampled together with each input. Direct-mode inputs neither add to nor advance the accumulator of their vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_mode | input | 1 | 0 = direct output, 1 = accumulate per vector; sampled with each input |
| clr_acc | input | 1 | One-cycle pulse that empties all accumulators |
| in_valid | input | 1 | Input strobe |
| in_vec | input | IDX_W (4) | Interleaved vector index |
| in_sum | input | DATA_W (16) | Signed distance sum |
| in_scale | input | COEF_W (16) | Signed scale coefficient |
| in_weight | input | DATA_W+COEF_W (32) | Signed weight added after scaling |
| out_valid | output | 1 | One-cycle result strobe |
| out_vec | output | IDX_W (4) | Vector index of the result |
| out_score | output | DATA_W+COEF_W+1+log2(COMPS) (36) | Signed score |
| dp_active | output | 1 | Registered datapath-awake flag |

## Verification
The bench builds the block with its default parameters: ten vectors, eight components per score, and a 4-bit index. With a 4-bit index, the six out-of-range codes 10 to 15 can be driven, so random traffic hits the ignore path. With eight components and ten vectors, fully interleaved back-to-back rounds of 80 inputs are short enough to run often. Full-scale 16-bit operands push the 36-bit accumulator to its extreme products, while the activity flag is tracked against a three-deep history of accepted inputs on every cycle.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
  typedef enum logic {
    MODE_DIRECT = 1'b0,
    MODE_ACCUM  = 1'b1
  } fsu_mode_e;

  localparam int unsigned MAC_STAGES = 2;
endpackage

// File: rtl/fsu_gate.sv
// Activity gate: enables the multiply-add registers only while work is in flight.
module fsu_gate (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic s1_vld,
  input  logic s2_vld,
  output logic dp_en,
  output logic dp_active
);
  always_comb dp_en = take | s1_vld | s2_vld;

  always_ff @(posedge clk) begin
    if (rst) dp_active <= 1'b0;
    else     dp_active <= dp_en;
  end
endmodule

// File: rtl/fsu_mac.sv
// Two-stage fixed-point multiply-add with the vector tag carried alongside.
module fsu_mac #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int IDX_W  = 4,
  localparam int PROD_W = DATA_W + COEF_W,
  localparam int MAC_W  = PROD_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic                     take,
  input  logic                     in_acc,
  input  logic [IDX_W-1:0]         in_vec,
  input  logic signed [DATA_W-1:0] in_sum,
  input  logic signed [COEF_W-1:0] in_scale,
  input  logic signed [PROD_W-1:0] in_weight,
  output logic                     s1_vld,
  output logic                     s2_vld,
  output logic                     s2_acc,
  output logic [IDX_W-1:0]         s2_vec,
  output logic signed [MAC_W-1:0]  s2_res
);
  logic signed [PROD_W-1:0] prod1;
  logic signed [PROD_W-1:0] wgt1;
  logic [IDX_W-1:0]         vec1;
  logic                     acc1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      s2_vld <= 1'b0;
    end else begin
      s1_vld <= take;
      s2_vld <= s1_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      prod1  <= in_sum * in_scale;
      wgt1   <= in_weight;
      vec1   <= in_vec;
      acc1   <= in_acc;
      s2_res <= {prod1[PROD_W-1], prod1} + {wgt1[PROD_W-1], wgt1};
      s2_vec <= vec1;
      s2_acc <= acc1;
    end
  end
endmodule

// File: rtl/fsu_accum.sv
// Per-vector score accumulators with component counting and the output register.
module fsu_accum #(
  parameter int NUM_VEC = 10,
  parameter int COMPS   = 8,
  parameter int IDX_W   = 4,
  parameter int MAC_W   = 33,
  parameter int ACC_W   = 36,
  localparam int CNT_W  = $clog2(COMPS + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    vld,
  input  logic                    acc,
  input  logic [IDX_W-1:0]        vec,
  input  logic signed [MAC_W-1:0] res,
  output logic                    out_valid,
  output logic [IDX_W-1:0]        out_vec,
  output logic signed [ACC_W-1:0] out_score
);
  logic signed [ACC_W-1:0] mem [NUM_VEC];
  logic [CNT_W-1:0]        cnt_q [NUM_VEC];

  logic signed [ACC_W-1:0] res_x;
  logic signed [ACC_W-1:0] base;
  logic signed [ACC_W-1:0] total;
  logic                    last;
  logic                    acc_upd;
  logic                    fire;

  always_comb begin
    res_x   = {{(ACC_W-MAC_W){res[MAC_W-1]}}, res};
    base    = (cnt_q[vec] == '0) ? '0 : mem[vec];
    total   = base + res_x;
    last    = (cnt_q[vec] == CNT_W'(COMPS - 1));
    acc_upd = vld && acc && !clr;
    fire    = vld && (!acc || (!clr && last));
  end

  // Storage without reset so it can map to memory; emptiness lives in cnt_q.
  always_ff @(posedge clk) begin
    if (acc_upd) mem[vec] <= total;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < NUM_VEC; i++) cnt_q[i] <= '0;
    end else if (acc_upd) begin
      cnt_q[vec] <= last ? '0 : cnt_q[vec] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_vec   <= '0;
      out_score <= '0;
    end else begin
      out_valid <= fire;
      if (fire) begin
        out_vec   <= vec;
        out_score <= acc ? total : res_x;
      end
    end
  end
endmodule

// File: rtl/final_score_unit.sv
module final_score_unit #(
  parameter int DATA_W  = 16,
  parameter int COEF_W  = 16,
  parameter int IDX_W   = 4,
  parameter int NUM_VEC = 10,
  parameter int COMPS   = 8,
  localparam int PROD_W = DATA_W + COEF_W,
  localparam int MAC_W  = PROD_W + 1,
  localparam int ACC_W  = MAC_W + $clog2(COMPS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     acc_mode,
  input  logic                     clr_acc,
  input  logic                     in_valid,
  input  logic [IDX_W-1:0]         in_vec,
  input  logic signed [DATA_W-1:0] in_sum,
  input  logic signed [COEF_W-1:0] in_scale,
  input  logic signed [PROD_W-1:0] in_weight,
  output logic                     out_valid,
  output logic [IDX_W-1:0]         out_vec,
  output logic signed [ACC_W-1:0]  out_score,
  output logic                     dp_active
);
  import fsu_pkg::*;

  localparam logic [IDX_W:0] VEC_LIM = (IDX_W+1)'(NUM_VEC);

  logic                    take;
  logic                    dp_en;
  logic                    s1_vld;
  logic                    s2_vld;
  logic                    s2_acc;
  logic [IDX_W-1:0]        s2_vec;
  logic signed [MAC_W-1:0] s2_res;
  fsu_mode_e               mode;

  always_comb begin
    mode = fsu_mode_e'(acc_mode);
    take = in_valid && ({1'b0, in_vec} < VEC_LIM);
  end

  fsu_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .take      (take),
    .s1_vld    (s1_vld),
    .s2_vld    (s2_vld),
    .dp_en     (dp_en),
    .dp_active (dp_active)
  );

  fsu_mac #(
    .DATA_W (DATA_W),
    .COEF_W (COEF_W),
    .IDX_W  (IDX_W)
  ) u_mac (
    .clk       (clk),
    .rst       (rst),
    .en        (dp_en),
    .take      (take),
    .in_acc    (mode == MODE_ACCUM),
    .in_vec    (in_vec),
    .in_sum    (in_sum),
    .in_scale  (in_scale),
    .in_weight (in_weight),
    .s1_vld    (s1_vld),
    .s2_vld    (s2_vld),
    .s2_acc    (s2_acc),
    .s2_vec    (s2_vec),
    .s2_res    (s2_res)
  );

  fsu_accum #(
    .NUM_VEC (NUM_VEC),
    .COMPS   (COMPS),
    .IDX_W   (IDX_W),
    .MAC_W   (MAC_W),
    .ACC_W   (ACC_W)
  ) u_accum (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr_acc),
    .vld       (s2_vld),
    .acc       (s2_acc),
    .vec       (s2_vec),
    .res       (s2_res),
    .out_valid (out_valid),
    .out_vec   (out_vec),
    .out_score (out_score)
  );
endmodule

// File: rtl/fsu_chk.sv
module fsu_chk #(
  parameter int IDX_W   = 4,
  parameter int NUM_VEC = 10,
  parameter int ACC_W   = 36
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic [IDX_W-1:0]        in_vec,
  input logic                    out_valid,
  input logic [IDX_W-1:0]        out_vec,
  input logic signed [ACC_W-1:0] out_score,
  input logic                    dp_active
);
  logic in_ok;
  always_comb in_ok = in_valid && ({1'b0, in_vec} < (IDX_W+1)'(NUM_VEC));

  // R6
  wake_chk: assert property (@(posedge clk) disable iff (rst)
    in_ok |=> dp_active);

  // R6
  sleep_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dp_active) |-> !$past(in_ok));

  // R1
  busy_out_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> dp_active);

  // R5
  vec_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ({1'b0, out_vec} < (IDX_W+1)'(NUM_VEC)));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_score) && $stable(out_vec)));
endmodule

bind final_score_unit fsu_chk #(
  .IDX_W   (IDX_W),
  .NUM_VEC (NUM_VEC),
  .ACC_W   (ACC_W)
) u_fsu_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_vec    (in_vec),
  .out_valid (out_valid),
  .out_vec   (out_vec),
  .out_score (out_score),
  .dp_active (dp_active)
);

// File: tb/test_final_score_unit.sv
`timescale 1ns/1ps
module test_final_score_unit;
  localparam int DATA_W  = 16;
  localparam int COEF_W  = 16;
  localparam int IDX_W   = 4;
  localparam int NUM_VEC = 10;
  localparam int COMPS   = 8;
  localparam int PROD_W  = DATA_W + COEF_W;
  localparam int ACC_W   = PROD_W + 1 + $clog2(COMPS);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                     rst = 1'b1;
  logic                     acc_mode = 1'b0;
  logic                     clr_acc = 1'b0;
  logic                     in_valid = 1'b0;
  logic [IDX_W-1:0]         in_vec = '0;
  logic signed [DATA_W-1:0] in_sum = '0;
  logic signed [COEF_W-1:0] in_scale = '0;
  logic signed [PROD_W-1:0] in_weight = '0;
  logic                     out_valid;
  logic [IDX_W-1:0]         out_vec;
  logic signed [ACC_W-1:0]  out_score;
  logic                     dp_active;

  final_score_unit #(
    .DATA_W (DATA_W), .COEF_W (COEF_W), .IDX_W (IDX_W),
    .NUM_VEC(NUM_VEC), .COMPS (COMPS)
  ) i_final_score_unit (
    .clk(clk), .rst(rst), .acc_mode(acc_mode), .clr_acc(clr_acc),
    .in_valid(in_valid), .in_vec(in_vec), .in_sum(in_sum),
    .in_scale(in_scale), .in_weight(in_weight), .out_valid(out_valid),
    .out_vec(out_vec), .out_score(out_score), .dp_active(dp_active)
  );

  int     checks = 0;
  int     fails  = 0;
  int     cyc    = 0;
  bit     done   = 0;
  int     q_vec[$];
  longint q_score[$];
  int     q_due[$];
  string  q_tag[$];
  longint m_acc[NUM_VEC];
  int     m_cnt[NUM_VEC];
  logic [2:0] hist = '0;
  longint last_score = 0;
  int     last_vec = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic longint mac(logic signed [DATA_W-1:0] s,
                                 logic signed [COEF_W-1:0] k,
                                 logic signed [PROD_W-1:0] w);
    return longint'(s) * longint'(k) + longint'(w);
  endfunction

  // Called at a falling edge: checks what the previous rising edge produced.
  task automatic observe();
    bit cur_take;
    cyc++;
    cur_take = in_valid && (int'(in_vec) < NUM_VEC);
    hist = {hist[1:0], cur_take};
    chk(dp_active == (|hist), "R6 dp_active", longint'(dp_active), longint'(|hist));
    if (out_valid) begin
      if (q_vec.size() == 0) begin
        chk(0, "R5 unexpected output", longint'(out_vec), -1);
      end else begin
        int     ev = q_vec.pop_front();
        longint es = q_score.pop_front();
        int     ed = q_due.pop_front();
        string  et = q_tag.pop_front();
        chk(int'(out_vec) == ev, {et, " vec"}, longint'(out_vec), longint'(ev));
        chk(longint'(out_score) == es, {et, " score"}, longint'(out_score), es);
        chk(cyc == ed, {et, " latency"}, longint'(cyc), longint'(ed));
      end
      last_score = longint'(out_score);
      last_vec   = int'(out_vec);
    end else begin
      chk(longint'(out_score) == last_score && int'(out_vec) == last_vec,
          "R7 hold", longint'(out_score), last_score);
    end
  endtask

  task automatic step(bit v, int vec, logic signed [DATA_W-1:0] s,
                      logic signed [COEF_W-1:0] k, logic signed [PROD_W-1:0] w,
                      bit mode, bit clr, string tag);
    @(negedge clk);
    observe();
    if (clr) for (int i = 0; i < NUM_VEC; i++) m_cnt[i] = 0;
    if (v && vec < NUM_VEC) begin
      longint r = mac(s, k, w);
      if (!mode) begin
        q_vec.push_back(vec); q_score.push_back(r);
        q_due.push_back(cyc + 3); q_tag.push_back(tag);
      end else begin
        m_acc[vec] = (m_cnt[vec] == 0 ? 0 : m_acc[vec]) + r;
        m_cnt[vec]++;
        if (m_cnt[vec] == COMPS) begin
          q_vec.push_back(vec); q_score.push_back(m_acc[vec]);
          q_due.push_back(cyc + 3); q_tag.push_back(tag);
          m_cnt[vec] = 0;
        end
      end
    end
    in_valid  = v;
    in_vec    = IDX_W'(vec);
    in_sum    = s;
    in_scale  = k;
    in_weight = w;
    acc_mode  = mode;
    clr_acc   = clr;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, '0, '0, '0, acc_mode, 0, "idle");
  endtask

  task automatic rnd_in(bit mode, int vec, string tag);
    step(1, vec, DATA_W'($urandom), COEF_W'($urandom), PROD_W'($urandom), mode, 0, tag);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NUM_VEC; i++) begin m_acc[i] = 0; m_cnt[i] = 0; end
    repeat (4) @(negedge clk);
    // R8: reset state
    chk(out_valid == 0, "R8 out_valid", longint'(out_valid), 0);
    chk(dp_active == 0, "R8 dp_active", longint'(dp_active), 0);
    chk(out_score == 0, "R8 out_score", longint'(out_score), 0);
    chk(out_vec == 0, "R8 out_vec", longint'(out_vec), 0);
    rst = 1'b0;
    idle(3);

    // R1: direct mode, every vector, plus full-scale corners
    for (int v = 0; v < NUM_VEC; v++) rnd_in(0, v, "R1 direct");
    step(1, 9, -16'sd32768, -16'sd32768, 32'sh7fffffff, 0, 0, "R1 corner max");
    step(1, 0, -16'sd32768, 16'sd32767, -32'sd2147483648, 0, 0, "R1 corner min");
    step(1, 4, 16'sd0, 16'sd123, -32'sd5, 0, 0, "R1 zero sum");
    idle(5);

    // R5: out-of-range indices in both modes, datapath stays asleep
    step(1, 10, 16'sd7, 16'sd7, 32'sd7, 0, 0, "R5");
    step(1, 15, 16'sd7, 16'sd7, 32'sd7, 1, 0, "R5");
    step(1, 12, 16'sd7, 16'sd7, 32'sd7, 1, 0, "R5");
    idle(5);

    // R2: one vector, gaps between components
    for (int c = 0; c < COMPS; c++) begin
      rnd_in(1, 3, "R2 accumulate");
      idle(c % 3);
    end
    idle(5);

    // R3: fully interleaved back-to-back rounds
    for (int r = 0; r < COMPS; r++)
      for (int v = 0; v < NUM_VEC; v++) rnd_in(1, (v + r) % NUM_VEC, "R3 interleave");
    idle(5);

    // R4: partial sum then clear, then a clean set
    for (int c = 0; c < 5; c++) rnd_in(1, 6, "R4 partial");
    idle(4);
    step(0, 0, '0, '0, '0, 1, 1, "R4 clear");
    idle(2);
    for (int c = 0; c < COMPS; c++) rnd_in(1, 6, "R4 after clear");
    idle(5);

    // R9: direct input between accumulate inputs of the same vector
    for (int c = 0; c < 3; c++) rnd_in(1, 2, "R9 accumulate");
    rnd_in(0, 2, "R9 direct");
    rnd_in(0, 2, "R9 direct");
    for (int c = 0; c < COMPS - 3; c++) rnd_in(1, 2, "R9 accumulate");
    idle(5);

    // Random traffic, modes switching per block
    for (int b = 0; b < 12; b++) begin
      bit mode = 1'($urandom);
      for (int i = 0; i < 200; i++) begin
        if ($urandom % 2) rnd_in(mode, int'($urandom % 16), mode ? "R2 random" : "R1 random");
        else idle(1);
      end
      idle(4);
      if (b % 4 == 3) step(0, 0, '0, '0, '0, mode, 1, "R4 clear");
    end
    idle(8);

    // R2: nothing left outstanding
    chk(q_vec.size() == 0, "R2 missing outputs", longint'(q_vec.size()), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule